// File: doc/BRIEF.md
# Byte-stream bridge to a USB chip's asynchronous FIFO port

This block links two byte streams inside the FPGA to the parallel FIFO port of an external USB bridge chip. The chip has no clock in common with the FPGA. It reports its state on two active-low flags: one says the host has sent at least one byte, and the other says the chip has room for a byte headed to the host. Bytes cross in both directions over one shared 8-bit bus, and each byte is moved by a strobe pulse. The block synchronises both flags, chooses the next transfer, times the strobe pulses and the quiet gaps between them, and controls the pad driver so that the FPGA drives the bus only while it is writing.

On the FPGA side, bytes from the host appear on a valid/ready output stream through a one-byte holding slot. Bytes for the host enter on a valid/ready input stream. Outside the block, the pad is built as a tri-state buffer from `bus_out`, `bus_oe` and `bus_in`.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is held, and after it is released, both strobes are high, `bus_oe` is 0, `rx_valid` is 0 and `tx_ready` is 0. Each flag passes through SYNC_STAGES (default 2) flip-flops that reset to the inactive level, so a flag that is already low at release first produces a falling strobe at the third rising edge after release.
- R2: A read starts only when the synchronised host flag is low and the holding slot is empty. The byte on `bus_in` is captured at the clock edge that ends the read pulse and then appears on `rx_data` with `rx_valid` = 1. While the host flag is high, or the slot is full, no read starts.
- R3: A write starts only when the synchronised room flag is low and `tx_valid` = 1. The byte is accepted in a cycle where `tx_valid` and `tx_ready` are both 1. While the room flag is high, `tx_ready` stays 0 and no write starts.
- R4: When a read and a write could both start in the same cycle, the read goes first.
- R5: Each strobe stays low for exactly STROBE_CYCLES clocks (default 3).
- R6: Between the rising edge of one strobe and the falling edge of the next, both strobes stay high for at least GAP_CYCLES+1 clocks (default GAP_CYCLES is 2).
- R7: `bus_oe` is 1 only around a write. It rises one clock before the write strobe falls and stays 1 for one clock after that strobe rises. It is never 1 while the read strobe is low, and it has been 0 for at least one clock when the read strobe falls.
- R8: While the write strobe is low and at its rising edge, `bus_out` holds the accepted byte unchanged.
- R9: While `rx_valid` = 1 and `rx_ready` = 0, `rx_valid` stays 1 and `rx_data` does not change.
- R10: The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_avail_n | input | 1 | Chip flag, low when a host byte is waiting (asynchronous) |
| room_avail_n | input | 1 | Chip flag, low when the chip can take a byte (asynchronous) |
| rd_strobe_n | output | 1 | Read strobe to the chip, active low |
| wr_strobe_n | output | 1 | Write strobe to the chip, active low |
| bus_in | input | 8 | Value seen on the shared data bus pads |
| bus_out | output | 8 | Byte driven onto the pads when `bus_oe` = 1 |
| bus_oe | output | 1 | Pad output enable, high only around a write |
| rx_data | output | 8 | Byte received from the host |
| rx_valid | output | 1 | `rx_data` holds a byte |
| rx_ready | input | 1 | Consumer takes the byte |
| tx_data | input | 8 | Byte to send to the host |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Block accepts `tx_data` in this cycle |

## Verification
The main function is exercised with several patterns. Reads run back to back from a queued host model, and comparing the byte order catches capture-timing faults. Writes run back to back, and comparing against what the chip model latched at each strobe rise catches missing setup or hold. Each stream is also held back, either by `rx_ready` low or by the room flag high, to show that exactly one transfer, or none, takes place. Finally, both flags are released in the same cycle, which separates read-first arbitration from write-first. Throughout, a bus monitor measures every pulse width and every gap, watches for the enable and the read strobe overlapping, and counts the clocks from reset release to the first strobe.

// File: rtl/usbfb_pkg.sv
`timescale 1ns/1ps
package usbfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD       = 3'd1,
    ST_WR_SETUP = 3'd2,
    ST_WR       = 3'd3,
    ST_WR_HOLD  = 3'd4,
    ST_GAP      = 3'd5
  } bstate_t;

  // Bits needed to hold a down-count starting at (max(a,b) - 1).
  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

  // True for every state in which the FPGA owns the shared bus.
  function automatic logic drives_bus(input bstate_t s);
    return (s == ST_WR_SETUP) || (s == ST_WR) || (s == ST_WR_HOLD);
  endfunction

endpackage

// File: rtl/usbfb_sync.sv
`timescale 1ns/1ps
module usbfb_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= {WIDTH{RST_VAL}};
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= {WIDTH{RST_VAL}};
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/usbfb_timer.sv
`timescale 1ns/1ps
module usbfb_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/usbfb_rx_slot.sv
`timescale 1ns/1ps
module usbfb_rx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] din,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (capture) begin
      rx_valid <= 1'b1;
      rx_data  <= din;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/usbfb_ctrl.sv
`timescale 1ns/1ps
module usbfb_ctrl
  import usbfb_pkg::*;
#(
  parameter int STROBE_CYCLES = 3,
  parameter int GAP_CYCLES    = 2,
  parameter int CW            = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_pending,
  input  logic          room_free,
  input  logic          slot_free,
  input  logic          tx_valid,
  input  logic          timer_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          rd_go,
  output logic          wr_go,
  output logic          tx_ready,
  output logic          capture,
  output logic          rd_strobe_n,
  output logic          wr_strobe_n,
  output logic          bus_oe
);

  localparam logic [CW-1:0] STB_LD = CW'(STROBE_CYCLES - 1);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYCLES - 1);

  bstate_t state, nxt;
  logic    rd_ok;
  logic    in_idle;

  assign in_idle  = (state == ST_IDLE);
  assign rd_ok    = host_pending && slot_free;
  assign rd_go    = in_idle && rd_ok;
  assign tx_ready = in_idle && room_free && !rd_ok;
  assign wr_go    = tx_ready && tx_valid;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rd_go) begin
          nxt      = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = STB_LD;
        end else if (wr_go) begin
          nxt = ST_WR_SETUP;
        end
      end
      ST_RD: begin
        if (timer_done) begin
          nxt      = ST_GAP;
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end
      end
      ST_WR_SETUP: begin
        nxt      = ST_WR;
        tmr_load = 1'b1;
        tmr_val  = STB_LD;
      end
      ST_WR: begin
        if (timer_done) nxt = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        nxt      = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      ST_GAP: begin
        if (timer_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // Pad-facing outputs come straight from flip-flops, decoded from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rd_strobe_n <= 1'b1;
      wr_strobe_n <= 1'b1;
      bus_oe      <= 1'b0;
    end else begin
      state       <= nxt;
      rd_strobe_n <= (nxt != ST_RD);
      wr_strobe_n <= (nxt != ST_WR);
      bus_oe      <= drives_bus(nxt);
    end
  end

endmodule

// File: rtl/usb_fifo_bridge.sv
`timescale 1ns/1ps
module usb_fifo_bridge #(
  parameter int STROBE_CYCLES = 3,
  parameter int GAP_CYCLES    = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_avail_n,
  input  logic       room_avail_n,
  output logic       rd_strobe_n,
  output logic       wr_strobe_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready
);

  localparam int CW = usbfb_pkg::cnt_width(STROBE_CYCLES, GAP_CYCLES);

  logic [1:0]    flags_q;
  logic          host_pending;
  logic          room_free;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          timer_done;
  logic          rd_go;
  logic          wr_go;
  logic          capture;

  usbfb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({room_avail_n, host_avail_n}),
    .q     (flags_q)
  );

  assign host_pending = !flags_q[0];
  assign room_free    = !flags_q[1];

  usbfb_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (timer_done)
  );

  usbfb_ctrl #(
    .STROBE_CYCLES (STROBE_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES),
    .CW            (CW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_pending (host_pending),
    .room_free    (room_free),
    .slot_free    (!rx_valid),
    .tx_valid     (tx_valid),
    .timer_done   (timer_done),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .rd_go        (rd_go),
    .wr_go        (wr_go),
    .tx_ready     (tx_ready),
    .capture      (capture),
    .rd_strobe_n  (rd_strobe_n),
    .wr_strobe_n  (wr_strobe_n),
    .bus_oe       (bus_oe)
  );

  usbfb_rx_slot #(.DW(8)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .din      (bus_in),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  // Outbound byte register: loaded on acceptance, held through the whole write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_out <= '0;
    else if (wr_go) bus_out <= tx_data;
  end

endmodule

// File: rtl/usb_fifo_bridge_checker.sv
`timescale 1ns/1ps
module usb_fifo_bridge_checker #(
  parameter int STROBE_CYCLES = 3,
  parameter int GAP_CYCLES    = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe_n,
  input logic       wr_strobe_n,
  input logic       bus_oe,
  input logic [7:0] bus_out,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       capture
);

  int unsigned rd_len, wr_len, high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_len   <= 0;
      wr_len   <= 0;
      high_run <= GAP_CYCLES + 1;
    end else begin
      rd_len   <= rd_strobe_n ? 0 : rd_len + 1;
      wr_len   <= wr_strobe_n ? 0 : wr_len + 1;
      if (rd_strobe_n && wr_strobe_n) high_run <= (high_run < 1000) ? high_run + 1 : high_run;
      else                            high_run <= 0;
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !rd_strobe_n)); // R7
  AST_OE_QUIET_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_strobe_n) |-> !$past(bus_oe)); // R7
  AST_OE_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_strobe_n) |-> $past(bus_oe)); // R7
  AST_OE_HOLD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strobe_n) |-> bus_oe); // R7
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n)); // R10
  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strobe_n) |-> (rd_len == STROBE_CYCLES)); // R5
  AST_WRITE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strobe_n) |-> (wr_len == STROBE_CYCLES)); // R5
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_strobe_n) || $fell(wr_strobe_n)) |-> (high_run >= GAP_CYCLES + 1)); // R6
  AST_READ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_strobe_n) |-> !$past(rx_valid)); // R2
  AST_CAPTURE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rx_valid); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
  AST_TX_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (bus_oe && bus_out == $past(tx_data))); // R3
  AST_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_strobe_n && !$past(wr_strobe_n)) |-> $stable(bus_out)); // R8

endmodule

bind usb_fifo_bridge usb_fifo_bridge_checker #(
  .STROBE_CYCLES (STROBE_CYCLES),
  .GAP_CYCLES    (GAP_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_strobe_n (rd_strobe_n),
  .wr_strobe_n (wr_strobe_n),
  .bus_oe      (bus_oe),
  .bus_out     (bus_out),
  .rx_data     (rx_data),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .tx_data     (tx_data),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .capture     (capture)
);

// File: tb/usb_fifo_bridge_test.sv
`timescale 1ns/1ps
module usb_fifo_bridge_test;

  localparam int STB = 3;
  localparam int GAP = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       host_avail_n, room_avail_n;
  logic       rd_strobe_n, wr_strobe_n;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;

  // Chip model state
  logic [7:0] host_mem [16];
  int         host_rd = 0, host_wr = 0;
  logic       host_hold = 1'b0;
  logic       room_block = 1'b1;

  assign host_avail_n = host_hold || (host_rd >= host_wr);
  assign room_avail_n = room_block;

  // Logs
  logic [7:0] rx_log [16];
  logic [7:0] wr_log [16];
  int n_rx, n_wr, n_rd, n_wr_start, first_kind;
  int n_chk = 0, n_err = 0;
  int cyc = 0;

  usb_fifo_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .host_avail_n(host_avail_n), .room_avail_n(room_avail_n),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_rx = 0; n_wr = 0; n_rd = 0; n_wr_start = 0; first_kind = 0;
  endtask

  // Bus monitor and chip model, evaluated away from the active edge.
  logic rd_q = 1'b1, wr_q = 1'b1, oe_q = 1'b0;
  int   rd_len = 0, wr_len = 0, gap = 99;
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_q = 1'b1; wr_q = 1'b1; oe_q = 1'b0; rd_len = 0; wr_len = 0; gap = 99;
    end else begin
      if (!rd_strobe_n && !wr_strobe_n) chk(1'b0, "R10 both strobes low", 1, 0);
      if (bus_oe && !rd_strobe_n) chk(1'b0, "R7 enable during read", 1, 0);
      if (rd_q && !rd_strobe_n) begin
        chk(!oe_q && !bus_oe, "R7 enable off before read", int'(oe_q), 0);
        chk(gap >= GAP + 1, "R6 gap before read", gap, GAP + 1);
        bus_in = host_mem[host_rd[3:0]];
        host_rd++;
        n_rd++;
        if (first_kind == 0) first_kind = 1;
      end
      if (wr_q && !wr_strobe_n) begin
        chk(oe_q && bus_oe, "R7 enable before write", int'(oe_q), 1);
        chk(gap >= GAP + 1, "R6 gap before write", gap, GAP + 1);
        n_wr_start++;
        if (first_kind == 0) first_kind = 2;
      end
      if (!rd_strobe_n) rd_len++;
      else if (!rd_q) begin
        chk(rd_len == STB, "R5 read pulse width", rd_len, STB);
        rd_len = 0;
      end
      if (!wr_strobe_n) wr_len++;
      else if (!wr_q) begin
        chk(wr_len == STB, "R5 write pulse width", wr_len, STB);
        chk(bus_oe, "R7 enable held after write", int'(bus_oe), 1);
        wr_log[n_wr[3:0]] = bus_out;
        n_wr++;
        wr_len = 0;
      end
      if (rd_strobe_n && wr_strobe_n) gap++;
      else gap = 0;
      if (rx_valid && rx_ready) begin
        rx_log[n_rx[3:0]] = rx_data;
        n_rx++;
      end
      rd_q = rd_strobe_n; wr_q = wr_strobe_n; oe_q = bus_oe;
    end
  end

  task automatic send_byte(input logic [7:0] v);
    tx_data  = v;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; host_hold = 1'b0; room_block = 1'b1; tx_valid = 1'b0; rx_ready = 1'b1;
    host_rd = 0; host_wr = 0; host_mem[0] = 8'hA5; host_wr = 1;
    clear_logs();
    repeat (3) @(negedge clk);
    chk(rd_strobe_n && wr_strobe_n, "R1 strobes high in reset", int'({rd_strobe_n, wr_strobe_n}), 3);
    chk(!bus_oe, "R1 bus released in reset", int'(bus_oe), 0);
    chk(!rx_valid && !tx_ready, "R1 streams idle in reset", int'({rx_valid, tx_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_strobe_n, "R1 no read after edge 1", int'(rd_strobe_n), 1);
    @(negedge clk);
    chk(rd_strobe_n, "R1 no read after edge 2", int'(rd_strobe_n), 1);
    @(negedge clk);
    chk(!rd_strobe_n, "R1 read starts at edge 3", int'(rd_strobe_n), 0);
    repeat (12) @(negedge clk);
    chk(n_rx == 1 && rx_log[0] == 8'hA5, "R2 first byte", int'(rx_log[0]), 'hA5);
  endtask

  task automatic t_reads();
    clear_logs();
    rx_ready = 1'b1;
    host_rd = 0; host_wr = 0;
    for (int i = 0; i < 4; i++) host_mem[i] = 8'(8'h10 + i * 17);
    host_wr = 4;
    repeat (60) @(negedge clk);
    chk(n_rx == 4, "R2 burst read count", n_rx, 4);
    for (int i = 0; i < 4; i++)
      chk(rx_log[i] == 8'(8'h10 + i * 17), "R2 burst read order", int'(rx_log[i]), 8'h10 + i * 17);
    repeat (20) @(negedge clk);
    chk(n_rd == 4, "R2 no read with host empty", n_rd, 4);
  endtask

  task automatic t_backpressure();
    clear_logs();
    rx_ready = 1'b0;
    host_rd = 0; host_wr = 0;
    host_mem[0] = 8'hC1; host_mem[1] = 8'hC2; host_wr = 2;
    repeat (40) @(negedge clk);
    chk(n_rd == 1, "R2 no read while slot full", n_rd, 1);
    chk(rx_valid, "R9 valid held", int'(rx_valid), 1);
    chk(rx_data == 8'hC1, "R9 data held", int'(rx_data), 'hC1);
    rx_ready = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_rx == 2, "R9 both bytes delivered", n_rx, 2);
    chk(rx_log[0] == 8'hC1 && rx_log[1] == 8'hC2, "R9 order after stall", int'(rx_log[1]), 'hC2);
  endtask

  task automatic t_writes();
    clear_logs();
    room_block = 1'b0;
    for (int i = 0; i < 4; i++) send_byte(8'(8'h50 + i));
    repeat (20) @(negedge clk);
    chk(n_wr == 4, "R3 burst write count", n_wr, 4);
    for (int i = 0; i < 4; i++)
      chk(wr_log[i] == 8'(8'h50 + i), "R8 latched byte", int'(wr_log[i]), 8'h50 + i);
    room_block = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_room_block();
    bit seen;
    clear_logs();
    seen = 1'b0;
    tx_data = 8'h3C; tx_valid = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (tx_ready) seen = 1'b1;
    end
    chk(!seen, "R3 no accept while chip full", int'(seen), 0);
    chk(n_wr_start == 0, "R3 no write while chip full", n_wr_start, 0);
    room_block = 1'b0;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (15) @(negedge clk);
    chk(n_wr == 1 && wr_log[0] == 8'h3C, "R3 write after room", int'(wr_log[0]), 'h3C);
    room_block = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_priority();
    clear_logs();
    host_hold = 1'b1; room_block = 1'b1; rx_ready = 1'b1;
    host_rd = 0; host_wr = 0; host_mem[0] = 8'h99; host_wr = 1;
    tx_data = 8'h77; tx_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_rd == 0 && n_wr_start == 0, "R4 idle while flags high", n_rd + n_wr_start, 0);
    host_hold = 1'b0; room_block = 1'b0;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(first_kind == 1, "R4 read wins", first_kind, 1);
    chk(n_rx == 1 && rx_log[0] == 8'h99, "R4 read byte", int'(rx_log[0]), 'h99);
    chk(n_wr == 1 && wr_log[0] == 8'h77, "R4 write follows", int'(wr_log[0]), 'h77);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reads();
    t_backpressure();
    t_writes();
    t_room_block();
    t_priority();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule